// File: doc/BRIEF.md
# Handshaked Single-Transfer Bus Controller

This block pairs an initiator controller with a responder controller over a small on-chip shared bus. The bus has three control wires (request, direction, reply) and one set of lines that carries the address first and the data afterwards. A client hands the initiator one command at a time (direction, address, write word). The initiator puts the address on the shared lines and raises request. It then waits for the responder's reply and moves the data. When the transfer is finished it raises a one-cycle done pulse, with the read word for a read.

The responder wraps a register array. The array is written with a synchronous read, so it maps onto block RAM. Reads pass through a fixed access latency, set by a parameter, before the reply rises with the data on the shared lines. Writes are answered at once, because the responder only needs to be ready to accept the word. Every transfer ends with a full four-phase handshake: request up, reply up, request down, reply down. A timeout bounds each transfer. If no reply arrives, the initiator withdraws its request and pulses an error flag. An input can silence the responder, which lets the timeout path be exercised.

Top module: `hs_xact_top`

## Requirements
- R1: While reset is high and in the cycle after it, request, reply, done and error are low, the shared lines read zero, and `cmd_ready` is high.
- R2: Request rises only while reply is low. Reply rises only while request is high. Request falls only after reply was high in the previous cycle, or together with an error pulse. Reply falls only once request is low.
- R3: A read accepted at clock edge 0 gives a done pulse after edge 4+LAT, and `rsp_rdata` then holds the word last written to that address.
- R4: A write accepted at edge 0 gives a done pulse after edge 4 for any LAT. A later read of that address returns the written word.
- R5: For a read, reply is high after edges 1+LAT and 2+LAT, and the shared lines carry the stored word during both cycles. For a write, reply is high after edges 1 and 2.
- R6: When the responder is silenced (`slv_resp_en` low), a transfer accepted at edge 0 ends with `rsp_err` high for the one cycle after edge TIMEOUT. Request is low from then on, there is no done pulse, and a timed-out write leaves the memory unchanged.
- R7: `cmd_ready` is low from the acceptance edge until the done or error edge. A `cmd_valid` presented while `cmd_ready` is low is ignored and does not alter the memory.
- R8: At most one side drives the shared lines. The initiator drives the address only in the cycle after acceptance. For a write it drives the data after edges 2 and 3. When neither side drives, the lines read zero.
- R9: Done and error are single-cycle pulses and never high together.
- R10: After a timeout, the next transfer with the responder enabled completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slv_resp_en | input | 1 | Responder answers requests when high |
| cmd_valid | input | 1 | Command offered; taken when `cmd_ready` is high |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Word address |
| cmd_wdata | input | DW | Write word |
| cmd_ready | output | 1 | Initiator idle and reply low |
| rsp_rdata | output | DW | Read word, valid with done after a read |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | One-cycle timeout pulse |
| bus_req_o | output | 1 | Request wire of the shared bus |
| bus_ack_o | output | 1 | Reply wire of the shared bus |
| bus_ad_o | output | ADW | Shared address/data lines |

## Verification
The bench targets the edges of the handshake. The read reply must come exactly LAT cycles after the responder sees the request; a latency counter that is off by one shifts done, and the reference flags the shift. A write must complete in four cycles no matter what LAT is; a design that waits out the access latency would be late. The silenced responder must produce exactly one error at cycle TIMEOUT, with the request withdrawn; a wrong counter bound, or a stuck request, would hang the next command or fire early. Commands offered while busy must neither start a second transfer nor leak into the memory, and the read-back after a timed-out write shows whether that write was wrongly committed.

// File: rtl/hs_xact_pkg.sv
package hs_xact_pkg;

  typedef enum logic [1:0] {
    MS_IDLE,
    MS_ADDR,
    MS_WAIT,
    MS_REL
  } mst_state_t;

  typedef enum logic [1:0] {
    SS_IDLE,
    SS_ACCESS,
    SS_HOLD
  } slv_state_t;

endpackage

// File: rtl/hs_xact_master.sv
module hs_xact_master
  import hs_xact_pkg::*;
#(
  parameter int AW      = 4,
  parameter int DW      = 16,
  parameter int ADW     = 16,
  parameter int TIMEOUT = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_valid,
  input  logic           cmd_write,
  input  logic [AW-1:0]  cmd_addr,
  input  logic [DW-1:0]  cmd_wdata,
  output logic           cmd_ready,
  output logic [DW-1:0]  rsp_rdata,
  output logic           rsp_done,
  output logic           rsp_err,
  output logic           bus_req,
  output logic           bus_wr,
  input  logic           bus_ack,
  input  logic [ADW-1:0] bus_ad_in,
  output logic           drv_en,
  output logic [ADW-1:0] drv_val
);

  localparam int TCW = $clog2(TIMEOUT + 1);
  localparam logic [TCW-1:0] TLAST = TCW'(TIMEOUT - 1);

  mst_state_t     st;
  logic [TCW-1:0] tcnt;
  logic [DW-1:0]  wdata_q;
  logic           expired;

  assign cmd_ready = (st == MS_IDLE) && !bus_ack;
  assign expired   = (tcnt == TLAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= MS_IDLE;
      bus_req   <= 1'b0;
      bus_wr    <= 1'b0;
      drv_en    <= 1'b0;
      drv_val   <= '0;
      rsp_rdata <= '0;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      tcnt      <= '0;
      wdata_q   <= '0;
    end else begin
      rsp_done <= 1'b0;
      rsp_err  <= 1'b0;
      unique case (st)
        MS_IDLE: begin
          if (cmd_valid && cmd_ready) begin
            st      <= MS_ADDR;
            bus_req <= 1'b1;
            bus_wr  <= cmd_write;
            drv_en  <= 1'b1;
            drv_val <= ADW'(cmd_addr);
            wdata_q <= cmd_wdata;
            tcnt    <= '0;
          end
        end
        MS_ADDR: begin
          drv_en  <= 1'b0;
          drv_val <= '0;
          tcnt    <= tcnt + 1'b1;
          st      <= MS_WAIT;
        end
        MS_WAIT: begin
          if (bus_ack) begin
            bus_req <= 1'b0;
            tcnt    <= tcnt + 1'b1;
            st      <= MS_REL;
            if (bus_wr) begin
              drv_en  <= 1'b1;
              drv_val <= ADW'(wdata_q);
            end else begin
              rsp_rdata <= bus_ad_in[DW-1:0];
            end
          end else if (expired) begin
            bus_req <= 1'b0;
            drv_en  <= 1'b0;
            drv_val <= '0;
            rsp_err <= 1'b1;
            st      <= MS_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        MS_REL: begin
          if (!bus_ack) begin
            drv_en   <= 1'b0;
            drv_val  <= '0;
            rsp_done <= 1'b1;
            st       <= MS_IDLE;
          end else if (expired) begin
            drv_en  <= 1'b0;
            drv_val <= '0;
            rsp_err <= 1'b1;
            st      <= MS_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: st <= MS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hs_xact_slave.sv
module hs_xact_slave
  import hs_xact_pkg::*;
#(
  parameter int AW  = 4,
  parameter int DW  = 16,
  parameter int ADW = 16,
  parameter int LAT = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           resp_en,
  input  logic           bus_req,
  input  logic           bus_wr,
  input  logic [ADW-1:0] bus_ad_in,
  output logic           bus_ack,
  output logic           drv_en,
  output logic [DW-1:0]  drv_val
);

  localparam int DEPTH = 1 << AW;
  localparam int LCW   = (LAT > 1) ? $clog2(LAT) : 1;

  slv_state_t     st;
  logic [AW-1:0]  addr_q;
  logic           wr_q;
  logic [LCW-1:0] lcnt;
  logic           req_d;
  logic           start;
  logic           mem_we;
  logic [DW-1:0]  rd_q;
  logic [DW-1:0]  mem [DEPTH];

  assign start   = resp_en && bus_req && !req_d;
  assign mem_we  = (st == SS_HOLD) && wr_q && !bus_req;
  assign drv_val = rd_q;

  always_ff @(posedge clk) begin
    if (mem_we) mem[addr_q] <= bus_ad_in[DW-1:0];
    rd_q <= mem[addr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SS_IDLE;
      bus_ack <= 1'b0;
      drv_en  <= 1'b0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      lcnt    <= '0;
      req_d   <= 1'b0;
    end else begin
      req_d <= bus_req;
      unique case (st)
        SS_IDLE: begin
          if (start) begin
            addr_q <= bus_ad_in[AW-1:0];
            wr_q   <= bus_wr;
            if (bus_wr) begin
              bus_ack <= 1'b1;
              st      <= SS_HOLD;
            end else begin
              lcnt <= LCW'(LAT - 1);
              st   <= SS_ACCESS;
            end
          end
        end
        SS_ACCESS: begin
          if (!bus_req) begin
            st <= SS_IDLE;
          end else if (lcnt == '0) begin
            bus_ack <= 1'b1;
            drv_en  <= 1'b1;
            st      <= SS_HOLD;
          end else begin
            lcnt <= lcnt - 1'b1;
          end
        end
        SS_HOLD: begin
          if (!bus_req) begin
            bus_ack <= 1'b0;
            drv_en  <= 1'b0;
            st      <= SS_IDLE;
          end
        end
        default: st <= SS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hs_xact_lines.sv
module hs_xact_lines #(
  parameter int DW  = 16,
  parameter int ADW = 16
) (
  input  logic           m_en,
  input  logic [ADW-1:0] m_val,
  input  logic           s_en,
  input  logic [DW-1:0]  s_val,
  output logic [ADW-1:0] lines
);

  always_comb begin
    lines = '0;
    if (m_en) lines = lines | m_val;
    if (s_en) lines = lines | ADW'(s_val);
  end

endmodule

// File: rtl/hs_xact_top.sv
module hs_xact_top #(
  parameter int AW      = 4,
  parameter int DW      = 16,
  parameter int LAT     = 3,
  parameter int TIMEOUT = 16,
  localparam int ADW    = (DW > AW) ? DW : AW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           slv_resp_en,
  input  logic           cmd_valid,
  input  logic           cmd_write,
  input  logic [AW-1:0]  cmd_addr,
  input  logic [DW-1:0]  cmd_wdata,
  output logic           cmd_ready,
  output logic [DW-1:0]  rsp_rdata,
  output logic           rsp_done,
  output logic           rsp_err,
  output logic           bus_req_o,
  output logic           bus_ack_o,
  output logic [ADW-1:0] bus_ad_o
);

  logic           bus_req;
  logic           bus_wr;
  logic           bus_ack;
  logic [ADW-1:0] bus_ad;
  logic           m_drv;
  logic [ADW-1:0] m_val;
  logic           s_drv;
  logic [DW-1:0]  s_val;

  hs_xact_master #(.AW(AW), .DW(DW), .ADW(ADW), .TIMEOUT(TIMEOUT)) u_mst (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_ack(bus_ack),
    .bus_ad_in(bus_ad), .drv_en(m_drv), .drv_val(m_val)
  );

  hs_xact_slave #(.AW(AW), .DW(DW), .ADW(ADW), .LAT(LAT)) u_slv (
    .clk(clk), .rst(rst), .resp_en(slv_resp_en),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_ad_in(bus_ad),
    .bus_ack(bus_ack), .drv_en(s_drv), .drv_val(s_val)
  );

  hs_xact_lines #(.DW(DW), .ADW(ADW)) u_lines (
    .m_en(m_drv), .m_val(m_val), .s_en(s_drv), .s_val(s_val), .lines(bus_ad)
  );

  assign bus_req_o = bus_req;
  assign bus_ack_o = bus_ack;
  assign bus_ad_o  = bus_ad;

endmodule

// File: rtl/hs_xact_chk.sv
module hs_xact_chk (
  input logic clk,
  input logic rst,
  input logic req,
  input logic ack,
  input logic mdrv,
  input logic sdrv,
  input logic done,
  input logic err,
  input logic ready
);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!req && !ack && !done && !err)); // R1
  AST_REQ_RISE_ACK_LOW: assert property (@(posedge clk) disable iff (rst) $rose(req) |-> $past(!ack)); // R2
  AST_ACK_RISE_REQ_HIGH: assert property (@(posedge clk) disable iff (rst) $rose(ack) |-> req); // R2
  AST_REQ_FALL_AFTER_ACK: assert property (@(posedge clk) disable iff (rst) $fell(req) |-> ($past(ack) || err)); // R2
  AST_ACK_FALL_REQ_LOW: assert property (@(posedge clk) disable iff (rst) $fell(ack) |-> !req); // R2
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst) req |-> !ready); // R7
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst) !(mdrv && sdrv)); // R8
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst) !(done && err)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R9
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst) err |=> !err); // R6

endmodule

bind hs_xact_top hs_xact_chk u_chk (
  .clk(clk), .rst(rst), .req(bus_req_o), .ack(bus_ack_o),
  .mdrv(m_drv), .sdrv(s_drv), .done(rsp_done), .err(rsp_err), .ready(cmd_ready)
);

// File: tb/sim_hs_xact_top.sv
module sim_hs_xact_top;

  localparam int AW = 4, DW = 16, LAT = 3, TO = 16;
  localparam int ADW = (DW > AW) ? DW : AW;

  logic clk = 1'b0, rst = 1'b1, slv_en = 1'b1;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic cmd_ready, rsp_done, rsp_err, bus_req, bus_ack;
  logic [DW-1:0] rsp_rdata;
  logic [ADW-1:0] bus_ad;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  hs_xact_top #(.AW(AW), .DW(DW), .LAT(LAT), .TIMEOUT(TO)) u0 (
    .clk(clk), .rst(rst), .slv_resp_en(slv_en),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .bus_req_o(bus_req),
    .bus_ack_o(bus_ack), .bus_ad_o(bus_ad)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: one transfer in flight, counted in edges since acceptance
  logic [DW-1:0] mem_m [int];
  bit busy = 0, k_wr = 0, k_to = 0, m_done = 0, m_err = 0;
  int e = 0, n_end = 0;
  logic [AW-1:0] k_addr;
  logic [DW-1:0] k_wd, m_rd;

  always @(posedge clk) begin
    m_done = 0;
    m_err  = 0;
    if (rst) busy = 0;
    else if (busy) begin
      e++;
      if (e == n_end) begin
        busy = 0;
        if (k_to) m_err = 1;
        else begin
          m_done = 1;
          if (k_wr) mem_m[int'(k_addr)] = k_wd;
          else m_rd = mem_m[int'(k_addr)];
        end
      end
    end else if (cmd_valid) begin
      busy = 1; e = 0;
      k_wr = cmd_write; k_addr = cmd_addr; k_wd = cmd_wdata; k_to = !slv_en;
      n_end = k_to ? TO : (k_wr ? 4 : 4 + LAT);
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      bit req_e, ack_e;
      int a0;
      logic [ADW-1:0] ad_e;
      a0    = k_wr ? 1 : 1 + LAT;
      req_e = busy && (e < (k_to ? TO : (k_wr ? 2 : 2 + LAT)));
      ack_e = busy && !k_to && (e >= a0) && (e < a0 + 2);
      ad_e  = '0;
      if (busy) begin
        if (e == 0) ad_e = ADW'(k_addr);
        else if (!k_wr && ack_e) ad_e = ADW'(mem_m[int'(k_addr)]);
        else if (k_wr && !k_to && e >= 2) ad_e = ADW'(k_wd);
      end
      chk("R2 request wire", 32'(bus_req), 32'(req_e));
      chk("R5 reply wire", 32'(bus_ack), 32'(ack_e));
      chk("R8 shared lines", 32'(bus_ad), 32'(ad_e));
      chk("R7 cmd_ready", 32'(cmd_ready), 32'(!busy));
      chk("R3 R4 R10 done", 32'(rsp_done), 32'(m_done));
      chk("R6 error", 32'(rsp_err), 32'(m_err));
      chk("R9 done and error exclusive", 32'(rsp_done && rsp_err), 32'd0);
      if (m_done && !k_wr) chk("R3 read word", 32'(rsp_rdata), 32'(m_rd));
    end
  end

  task automatic do_cmd(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk("R1 reset request", 32'(bus_req), 32'd0);
    chk("R1 reset reply", 32'(bus_ack), 32'd0);
    chk("R1 reset lines", 32'(bus_ad), 32'd0);
    chk("R1 reset ready", 32'(cmd_ready), 32'd1);
    chk("R1 reset done/err", 32'({rsp_done, rsp_err}), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    // R4: writes with varied patterns, back to back
    do_cmd(1, 4'd0, 16'hA5A5);
    do_cmd(1, 4'd15, 16'h5A5A);
    do_cmd(1, 4'd7, 16'hFFFF);
    do_cmd(1, 4'd3, 16'h0000);
    // R3 R5: reads back
    do_cmd(0, 4'd0, 16'h0);
    do_cmd(0, 4'd15, 16'h0);
    do_cmd(0, 4'd7, 16'h0);
    do_cmd(0, 4'd3, 16'h0);
    do_cmd(1, 4'd0, 16'h1234);
    do_cmd(0, 4'd0, 16'h0);
    // R7: commands offered while busy are ignored
    wait_idle();
    do_cmd(1, 4'd5, 16'hBEEF);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 4'd5; cmd_wdata = 16'hDEAD;
    repeat (2) @(negedge clk);
    cmd_valid = 1'b0;
    do_cmd(0, 4'd5, 16'h0);
    // R6: silenced responder, read and write time out
    wait_idle();
    slv_en = 1'b0;
    do_cmd(0, 4'd0, 16'h0);
    do_cmd(1, 4'd0, 16'h9999);
    wait_idle();
    slv_en = 1'b1;
    // R10: recovery, and the timed-out write left address 0 untouched
    do_cmd(0, 4'd0, 16'h0);
    do_cmd(0, 4'd5, 16'h0);
    wait_idle();
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule